// File: doc/BRIEF.md
# Subroutine Return Address Sequencer

This block is the part of a small 8-bit processor core that decides where control goes on a subroutine call, a return, a return from an interrupt handler and the entry into an interrupt handler. It holds an eight-deep stack of 15-bit return addresses inside the core. The 3-bit stack pointer and an interrupt-inhibit bit are kept here and shown as fields of the upper status word.

Each cycle the decoder presents one command. It also presents the current condition code, a condition selector, the address execution would fall through to and, for calls, the branch target. The block answers in the same cycle with the next program counter and a taken flag. The stack, the pointer and the inhibit bit are updated on the following clock edge.

For an interrupt, the device places a byte on the data bus. Its low seven bits are a signed displacement from address zero. Its top bit asks for one more level of indirection, which the fetch logic resolves. Instruction fetch and memory are outside this block.

Top module: `callret_unit`

## Requirements
- R1: After a synchronous active-low reset, the stack pointer is 0, the inhibit bit is 0 and every stack entry holds 0. Command NONE (code 0) gives taken 0 and next_pc equal to pc_ret_i.
- R2: The condition selector matches as follows: 0 when cc_i is 00 (zero), 1 when cc_i is 01 (positive), 2 when cc_i is 10 (negative), and 3 always. A cc_i of 11 matches only selector 3.
- R3: A CALL (code 1) whose condition matches is taken. next_pc is target_i. On the edge, the pointer advances by one and pc_ret_i is written into the entry the advanced pointer selects.
- R4: A RET (code 3) whose condition matches is taken. next_pc is the entry the pointer selects. On the edge, the pointer steps back by one.
- R5: A CALL, RET or RETI whose condition does not match is not taken. next_pc is pc_ret_i, and the pointer, the inhibit bit and every stack entry are left unchanged. Command codes 0, 6 and 7 have the same effect.
- R6: A CALL_NZ (code 2) is taken exactly when reg_nz_i is 1, whatever the condition inputs. When taken it pushes like R3.
- R7: An IRQ (code 5) with the inhibit bit clear is taken. It pushes pc_ret_i and sets the inhibit bit. next_pc is bus_disp_i[6:0] sign-extended to 15 bits, so negative values wrap to the top of the address space. vec_indirect_o equals bus_disp_i[7].
- R8: An IRQ while the inhibit bit is set is ignored. taken is 0, vec_indirect_o is 0, next_pc is pc_ret_i, and the stack and pointer are unchanged.
- R9: A RETI (code 4) uses the condition like RET. When taken it pops like R4 and clears the inhibit bit.
- R10: The pointer wraps modulo 8 in both directions with no error indication. A ninth nested push overwrites the oldest entry.
- R11: status_hi_o carries sense_i in bit 7, flag_i in bit 6, the inhibit bit in bit 5, zeros in bits 4:3 and the stack pointer in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command: 0 NONE, 1 CALL, 2 CALL_NZ, 3 RET, 4 RETI, 5 IRQ |
| cond_i | input | 2 | Condition selector |
| cc_i | input | 2 | Current condition code |
| reg_nz_i | input | 1 | Named register is non-zero |
| pc_ret_i | input | 15 | Fall-through (return) address |
| target_i | input | 15 | Call target |
| bus_disp_i | input | 8 | Interrupt vector byte from the device |
| sense_i | input | 1 | Sense pin level shown in the status word |
| flag_i | input | 1 | Flag output level shown in the status word |
| next_pc_o | output | 15 | Next program counter |
| taken_o | output | 1 | Control transfer taken |
| vec_indirect_o | output | 1 | Interrupt vector must be dereferenced |
| status_hi_o | output | 8 | Upper status word fields |

## Verification
The bench sweeps every command against every selector, condition code and register flag. It does this with the inhibit bit both set and clear, and it compares each result with a model of the stack. A wrong condition decode, especially for the code 11, would take branches that should fall through. A push that writes before advancing the pointer would make returns come back to the wrong address. An interrupt that ignored the inhibit bit would nest handlers and corrupt the stack. The bench nests ten calls deep and unwinds them, which exposes a pointer that saturates instead of wrapping. It also tries vector bytes at the sign boundary, where a zero-extending design would jump to low memory.

// File: rtl/callret_pkg.sv
// Shared encodings for the return address sequencer.
package callret_pkg;
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_CALL    = 3'd1,
        CMD_CALL_NZ = 3'd2,
        CMD_RET     = 3'd3,
        CMD_RETI    = 3'd4,
        CMD_IRQ     = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_GT   = 2'd1,
        SEL_LT   = 2'd2,
        SEL_ANY  = 2'd3
    } sel_e;

    localparam logic [1:0] CC_ZERO = 2'b00;
    localparam logic [1:0] CC_POS  = 2'b01;
    localparam logic [1:0] CC_NEG  = 2'b10;
endpackage

// File: rtl/callret_cond.sv
// Condition matcher: compares the selector with the condition code.
// Assumes the condition code encodings in callret_pkg; code 11 only meets "any".
module callret_cond
    import callret_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic [1:0] cc_i,
    output logic       match_o
);
    // Purpose: decode the selector into a match flag.
    always_comb begin
        unique case (sel_e'(sel_i))
            SEL_ZERO: match_o = (cc_i == CC_ZERO);
            SEL_GT:   match_o = (cc_i == CC_POS);
            SEL_LT:   match_o = (cc_i == CC_NEG);
            default:  match_o = 1'b1;
        endcase
    end

    // Purpose: the "any" selector must never block a transfer.
    always_comb begin
        assert_any_matches_R2: assert (sel_i != 2'd3 || match_o)
            else $error("R2: selector any did not match");
    end
endmodule

// File: rtl/callret_vec.sv
// Vector address former: turns the device byte into a zero-relative address.
// Assumes the low DISP_W-1 bits are a two's complement displacement and the
// top bit requests one level of indirection.
module callret_vec #(
    parameter int AW     = 15,
    parameter int DISP_W = 8
) (
    input  logic [DISP_W-1:0] disp_i,
    output logic [AW-1:0]     addr_o,
    output logic              indirect_o
);
    localparam int OFS_W = DISP_W - 1;

    // Purpose: sign-extend the displacement onto address zero.
    always_comb begin
        addr_o     = {{(AW-OFS_W){disp_i[OFS_W-1]}}, disp_i[OFS_W-1:0]};
        indirect_o = disp_i[DISP_W-1];
    end
endmodule

// File: rtl/callret_stack.sv
// Return address storage with a wrapping pointer.
// Push advances the pointer and then writes the entry it selects. Pop reads
// the current entry and steps the pointer back. DEPTH must be a power of two.
module callret_stack #(
    parameter int AW    = 15,
    parameter int DEPTH = 8,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] top_o,
    output logic [PW-1:0] sp_o
);
    localparam logic [PW-1:0] ONE = PW'(1);

    logic [AW-1:0] mem_q [DEPTH];
    logic [PW-1:0] sp_q;
    logic [PW-1:0] sp_up;

    assign sp_up = sp_q + ONE;
    assign top_o = mem_q[sp_q];
    assign sp_o  = sp_q;

    // Purpose: move the pointer on push or pop, wrapping silently.
    always_ff @(posedge clk) begin
        if (!rst_n)      sp_q <= '0;
        else if (push_i) sp_q <= sp_up;
        else if (pop_i)  sp_q <= sp_q - ONE;
    end

    // Purpose: clear all entries on reset and write the pushed address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (push_i && sp_up == PW'(i))
                mem_q[i] <= wdata_i;
        end
    end

    assert_one_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_i, pop_i}));
    assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> sp_q == $past(sp_q) + ONE);
    assert_push_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> mem_q[sp_q] == $past(wdata_i));
    assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |=> sp_q == $past(sp_q) - ONE);
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(sp_q));
endmodule

// File: rtl/callret_unit.sv
// Return address sequencer: resolves calls, returns, interrupt returns and
// vectored interrupt entry into a next program counter. It owns the return
// stack, its pointer and the interrupt-inhibit bit. Assumes one command per
// cycle. Outputs are combinational from the inputs and the current state.
module callret_unit
    import callret_pkg::*;
#(
    parameter int AW     = 15,
    parameter int DEPTH  = 8,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [1:0]        cond_i,
    input  logic [1:0]        cc_i,
    input  logic              reg_nz_i,
    input  logic [AW-1:0]     pc_ret_i,
    input  logic [AW-1:0]     target_i,
    input  logic [DISP_W-1:0] bus_disp_i,
    input  logic              sense_i,
    input  logic              flag_i,
    output logic [AW-1:0]     next_pc_o,
    output logic              taken_o,
    output logic              vec_indirect_o,
    output logic [7:0]        status_hi_o
);
    localparam int PW = $clog2(DEPTH);

    logic          cond_ok;
    logic [AW-1:0] vec_addr;
    logic          vec_ind;
    logic [AW-1:0] stk_top;
    logic [PW-1:0] sp;
    logic          push, pop;
    logic          irq_enter, reti_done;
    logic          inhibit_q;

    callret_cond u_cond (
        .sel_i   (cond_i),
        .cc_i    (cc_i),
        .match_o (cond_ok)
    );

    callret_vec #(.AW(AW), .DISP_W(DISP_W)) u_vec (
        .disp_i     (bus_disp_i),
        .addr_o     (vec_addr),
        .indirect_o (vec_ind)
    );

    callret_stack #(.AW(AW), .DEPTH(DEPTH), .PW(PW)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .wdata_i (pc_ret_i),
        .top_o   (stk_top),
        .sp_o    (sp)
    );

    // Purpose: pick the transfer and the stack operation for this command.
    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        irq_enter = 1'b0;
        reti_done = 1'b0;
        next_pc_o = pc_ret_i;
        case (cmd_e'(cmd_i))
            CMD_CALL: if (cond_ok) begin
                push      = 1'b1;
                next_pc_o = target_i;
            end
            CMD_CALL_NZ: if (reg_nz_i) begin
                push      = 1'b1;
                next_pc_o = target_i;
            end
            CMD_RET: if (cond_ok) begin
                pop       = 1'b1;
                next_pc_o = stk_top;
            end
            CMD_RETI: if (cond_ok) begin
                pop       = 1'b1;
                reti_done = 1'b1;
                next_pc_o = stk_top;
            end
            CMD_IRQ: if (!inhibit_q) begin
                push      = 1'b1;
                irq_enter = 1'b1;
                next_pc_o = vec_addr;
            end
            default: ;
        endcase
    end

    assign taken_o        = push | pop;
    assign vec_indirect_o = irq_enter & vec_ind;

    // Purpose: hold the interrupt-inhibit bit between entry and return.
    always_ff @(posedge clk) begin
        if (!rst_n)         inhibit_q <= 1'b0;
        else if (irq_enter) inhibit_q <= 1'b1;
        else if (reti_done) inhibit_q <= 1'b0;
    end

    // Purpose: present the upper status word fields.
    assign status_hi_o = {sense_i, flag_i, inhibit_q, {(5-PW){1'b0}}, sp};

    assert_irq_sets_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd5 && !inhibit_q) |=> inhibit_q);
    assert_irq_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd5 && inhibit_q) |-> (!taken_o && next_pc_o == pc_ret_i));
    assert_reti_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4 && taken_o) |=> !inhibit_q);
    assert_untaken_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> next_pc_o == pc_ret_i);
    assert_mask_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |=> $stable(inhibit_q));
endmodule

// File: tb/sim_callret_unit.sv
module sim_callret_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = '0;
    logic [1:0]  cond = '0, cc = '0;
    logic        nz = 1'b0;
    logic [14:0] pc = '0, tgt = '0;
    logic [7:0]  disp = '0;
    logic        sense = 1'b0, flag = 1'b0;
    logic [14:0] next_pc;
    logic        taken, vind;
    logic [7:0]  stat;

    int n_tests = 0;
    int n_fail  = 0;

    logic [14:0] m_stk [8];
    int m_sp = 0;
    int m_ii = 0;

    always #2 clk = ~clk;

    callret_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .cond_i(cond), .cc_i(cc),
        .reg_nz_i(nz), .pc_ret_i(pc), .target_i(tgt), .bus_disp_i(disp),
        .sense_i(sense), .flag_i(flag), .next_pc_o(next_pc), .taken_o(taken),
        .vec_indirect_o(vind), .status_hi_o(stat)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        return {sense, flag, m_ii[0], 2'b00, m_sp[2:0]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        m_sp = 0;
        m_ii = 0;
    endtask

    // One command: check the same-cycle answer, then the state after the edge.
    task automatic step(input logic [2:0] c, input logic [1:0] sl, input logic [1:0] cv,
                        input logic z, input logic [14:0] p, input logic [14:0] t,
                        input logic [7:0] d, input string force_tag);
        logic        m, tk, ind;
        logic [14:0] epc;
        string       tag;
        @(negedge clk);
        cmd = c; cond = sl; cc = cv; nz = z; pc = p; tgt = t; disp = d;
        #1;
        m   = (sl == 2'd3) || (sl == 2'd0 && cv == 2'b00) ||
              (sl == 2'd1 && cv == 2'b01) || (sl == 2'd2 && cv == 2'b10);
        tk  = 1'b0; epc = p; ind = 1'b0; tag = "R5";
        case (c)
            3'd1: begin tk = m; tag = "R3"; if (m) epc = t; end
            3'd2: begin tk = z; tag = "R6"; if (z) epc = t; end
            3'd3: begin tk = m; tag = "R4"; if (m) epc = m_stk[m_sp]; end
            3'd4: begin tk = m; tag = "R9"; if (m) epc = m_stk[m_sp]; end
            3'd5: begin
                tk = (m_ii == 0);
                tag = tk ? "R7" : "R8";
                if (tk) begin
                    epc = d[6] ? (15'h7F80 | 15'(d[6:0])) : 15'(d[6:0]);
                    ind = d[7];
                end
            end
            default: ;
        endcase
        if (!tk && c != 3'd5 && c != 3'd2) tag = "R5";
        if (force_tag != "") tag = force_tag;
        if (c == 3'd1 || c == 3'd3 || c == 3'd4) chk("R2", "taken vs condition", 32'(taken), 32'(tk));
        else chk(tag, "taken", 32'(taken), 32'(tk));
        chk(tag, "next_pc", 32'(next_pc), 32'(epc));
        chk(tag, "vec_indirect", 32'(vind), 32'(ind));
        chk("R11", "status before edge", 32'(stat), 32'(exp_stat()));
        if (tk) begin
            if (c == 3'd1 || c == 3'd2 || c == 3'd5) begin
                m_sp = (m_sp + 1) % 8;
                m_stk[m_sp] = p;
                if (c == 3'd5) m_ii = 1;
            end else begin
                m_sp = (m_sp + 7) % 8;
                if (c == 3'd4) m_ii = 0;
            end
        end
        @(posedge clk);
        #1;
        chk(tag, "status after edge", 32'(stat), 32'(exp_stat()));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd = 3'd1; cond = 2'd3;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        chk("R1", "status in reset", 32'(stat), 32'(exp_stat()));
        @(negedge clk);
        rst_n = 1'b1; cmd = 3'd0;
        #1;
        chk("R1", "taken idle", 32'(taken), 32'd0);
        chk("R1", "next_pc idle", 32'(next_pc), 32'(pc));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: entries read back as zero after reset.
        step(3'd3, 2'd3, 2'b00, 1'b0, 15'h0123, 15'h0, 8'h0, "R1");
        step(3'd3, 2'd3, 2'b00, 1'b0, 15'h0124, 15'h0, 8'h0, "R1");

        // Near-exhaustive sweep over command, selector, condition code, nz.
        for (int pass = 0; pass < 2; pass++) begin
            int n;
            n = 0;
            sense = pass[0];
            flag  = ~pass[0];
            for (int c = 0; c < 8; c++)
                for (int s = 0; s < 4; s++)
                    for (int v = 0; v < 4; v++)
                        for (int z = 0; z < 2; z++) begin
                            n++;
                            step(3'(c), 2'(s), 2'(v), z[0], 15'(n * 37 + 5 + pass * 911),
                                 15'(n * 113 + 7), 8'(n * 29 + pass), "");
                            // Interleave calls, returns and interrupt returns so
                            // that the inhibit bit and stack vary across the sweep.
                            if (n % 5 == 0)
                                step(3'd4, 2'd3, 2'b11, 1'b0, 15'(n), 15'h0, 8'h0, "");
                            if (n % 7 == 0)
                                step(3'd1, 2'(n % 4), 2'(n % 3), 1'b0, 15'(n * 3), 15'(n * 5), 8'h0, "");
                        end
        end

        // R7: vector bytes at the sign and indirection boundaries.
        step(3'd4, 2'd3, 2'b00, 1'b0, 15'h10, 15'h0, 8'h00, "R9");
        step(3'd5, 2'd0, 2'b00, 1'b0, 15'h1111, 15'h0, 8'h3F, "R7");
        step(3'd5, 2'd0, 2'b00, 1'b0, 15'h2222, 15'h0, 8'h40, "R8");
        step(3'd4, 2'd3, 2'b00, 1'b0, 15'h11, 15'h0, 8'h00, "R9");
        step(3'd5, 2'd0, 2'b00, 1'b0, 15'h3333, 15'h0, 8'h40, "R7");
        step(3'd4, 2'd3, 2'b00, 1'b0, 15'h12, 15'h0, 8'h00, "R9");
        step(3'd5, 2'd0, 2'b00, 1'b0, 15'h4444, 15'h0, 8'hC5, "R7");
        step(3'd4, 2'd3, 2'b00, 1'b0, 15'h13, 15'h0, 8'h00, "R9");
        step(3'd5, 2'd0, 2'b00, 1'b0, 15'h5555, 15'h0, 8'h80, "R7");
        step(3'd4, 2'd3, 2'b00, 1'b0, 15'h14, 15'h0, 8'h00, "R9");

        // R10: ten nested calls, then ten returns, wrapping both ways.
        for (int i = 0; i < 10; i++)
            step(3'd1, 2'd3, 2'b00, 1'b0, 15'(16'h0400 + i), 15'(16'h2000 + i), 8'h0, "R10");
        for (int i = 0; i < 10; i++)
            step(3'd3, 2'd3, 2'b01, 1'b0, 15'(16'h0500 + i), 15'h0, 8'h0, "R10");

        // R1: reset in mid-run returns everything to the initial state.
        do_reset();
        step(3'd3, 2'd3, 2'b00, 1'b0, 15'h0777, 15'h0, 8'h0, "R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule